// File: doc/BRIEF.md
# Serial Port Line Status Flag Register

This block collects the receive-side error conditions and the transmit-side occupancy of a 16550-style serial port into one 8-bit status word. The receiver feeds it single-cycle strobes for parity errors, framing errors and overruns, a level for "a received character is waiting", and a per-bit-time sample of the receive line. The transmitter feeds it two occupancy levels, one for the holding register and one for the shift register. A FIFO-mode enable and a FIFO-error level complete the inputs.

Error conditions are sticky. Once set, a flag stays set until the CPU reads the word. The read strobe returns the word as it stands in that cycle, and the sticky flags clear on the following clock edge. A line break is detected inside the block. It counts consecutive low samples of the receive line, taken at bit ticks, and compares the count against the length of one whole character frame. That length comes from the frame configuration inputs. One break is reported per low period.

The status word is a plain level output with no handshake. The block has no data stream, so there is no valid/ready interface and no back-pressure to handle.

Top module: `lsr_status_reg`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the bits data ready (bit 0), overrun (bit 1), parity error (bit 2), framing error (bit 3), break (bit 4) and FIFO error (bit 7) read 0. Bits 5 and 6 follow the transmitter inputs.
- R2: A parity error strobe sets bit 2 on the next clock edge. Bit 2 holds until a read strobe, and clears on the edge that ends the read cycle.
- R3: A framing error strobe, which the receiver raises when it samples the stop bit low, sets bit 3 with the same sticky hold-until-read behaviour as bit 2.
- R4: An overrun strobe sets the sticky bit 1, which clears on a read. Bit 0 follows the character-waiting level input directly and is not cleared by a read.
- R5: In a cycle where a read strobe and a set strobe are both high, the word reads the old value. The newly set flag stays latched and is seen by the next read.
- R6: Bit 4 sets once the receive line has been sampled low on more consecutive bit ticks than the frame length. The frame length is 1 start bit, plus 5 + len_code data bits (len_code 0..3 gives 5..8 bits), plus 1 parity bit when parity is on, plus 1 stop bit (2 stop bits when two_stop is set). Bit 4 clears on a read.
- R7: Only one break is reported per low period. After bit 4 has been read and cleared, further low samples do not set it again until a high sample has been seen. The low-sample counter saturates and does not wrap.
- R8: Bit 5 reads 1 when the holding register is empty and 0 when it holds a character.
- R9: Bit 6 reads 1 only when both the holding register and the shift register are empty.
- R10: Bit 7 reads 0 whenever FIFO mode is off. In FIFO mode it equals the FIFO-error level.
- R11: A high sample at a bit tick restarts the break count. Low runs broken by a high sample never add up to a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb_i | input | 1 | CPU read of the status word; clears sticky flags at the end of the cycle |
| rx_avail_i | input | 1 | Received character waiting (level) |
| overrun_stb_i | input | 1 | Overrun event strobe |
| par_err_stb_i | input | 1 | Parity error event strobe |
| frm_err_stb_i | input | 1 | Framing error event strobe |
| bit_tick_i | input | 1 | One-cycle pulse per bit period, marks a valid line sample |
| rx_line_i | input | 1 | Receive line level (1 = mark) |
| len_code_i | input | 2 | Data length code, 5 + code data bits |
| parity_on_i | input | 1 | Frame carries a parity bit |
| two_stop_i | input | 1 | Frame carries two stop bits |
| thr_full_i | input | 1 | Holding register occupied |
| tsr_busy_i | input | 1 | Shift register occupied |
| fifo_mode_i | input | 1 | FIFO mode enable |
| fifo_err_i | input | 1 | FIFO error level from the receive FIFO |
| status_o | output | 8 | Status word |

## Verification
The bench builds the block with its default 4-bit break counter. With that width the longest frame (12 bit times) sits just below the saturation value of 15. A run of 20 low samples therefore drives the counter into saturation, which shows that a saturated count neither wraps nor reports a second break within one low period. Two frame configurations (8N1, threshold 10, and 5 data bits with parity and two stop bits, threshold 9) place the break edge at different sample counts. This confirms that the threshold tracks the configuration inputs.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  // Bit positions inside the status word; software decodes them.
  localparam int BIT_DR   = 0;
  localparam int BIT_OE   = 1;
  localparam int BIT_PE   = 2;
  localparam int BIT_FE   = 3;
  localparam int BIT_BI   = 4;
  localparam int BIT_THRE = 5;
  localparam int BIT_TEMT = 6;
  localparam int BIT_FERR = 7;
  localparam int WORD_W   = 8;

  // Sticky flag bank slots.
  localparam int STICKY_N = 4;
  localparam int STK_OE = 0;
  localparam int STK_PE = 1;
  localparam int STK_FE = 2;
  localparam int STK_BI = 3;

  // Frame shape used to derive the break threshold.
  localparam int BASE_DATA_BITS = 5;
  localparam int LEN_CODE_W     = 2;

  typedef struct packed {
    logic [LEN_CODE_W-1:0] len_code;
    logic                  parity_on;
    logic                  two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/lsr_frame_len.sv
module lsr_frame_len
  import lsr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  frame_cfg_t       cfg_i,
  output logic [CNT_W-1:0] frame_bits_o
);
  // start + data + optional parity + one or two stop bits
  localparam logic [CNT_W-1:0] FIXED_BITS = CNT_W'(1 + BASE_DATA_BITS + 1);

  always_comb begin
    frame_bits_o = FIXED_BITS
                 + CNT_W'(cfg_i.len_code)
                 + CNT_W'(cfg_i.parity_on)
                 + CNT_W'(cfg_i.two_stop);
  end
endmodule

// File: rtl/lsr_break_timer.sv
module lsr_break_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             line_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             brk_evt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] low_cnt_q;
  logic             armed_q;
  logic             low_tick;

  assign low_tick = tick_i & ~line_i;
  // Fires on the sample that makes the low run exceed the frame length.
  assign brk_evt_o = low_tick & armed_q & (low_cnt_q >= thresh_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      armed_q   <= 1'b1;
    end else if (tick_i) begin
      if (line_i) begin
        low_cnt_q <= '0;
        armed_q   <= 1'b1;
      end else begin
        if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + 1'b1;
        if (brk_evt_o) armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lsr_sticky_bank.sv
module lsr_sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    // A set arriving with the clear wins, so the event is not lost.
    always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= (q & ~clr_i) | set_i[g];
    end
    assign flag_o[g] = q;
  end
endmodule

// File: rtl/lsr_status_reg.sv
module lsr_status_reg
  import lsr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_stb_i,
  input  logic       rx_avail_i,
  input  logic       overrun_stb_i,
  input  logic       par_err_stb_i,
  input  logic       frm_err_stb_i,
  input  logic       bit_tick_i,
  input  logic       rx_line_i,
  input  logic [1:0] len_code_i,
  input  logic       parity_on_i,
  input  logic       two_stop_i,
  input  logic       thr_full_i,
  input  logic       tsr_busy_i,
  input  logic       fifo_mode_i,
  input  logic       fifo_err_i,
  output logic [7:0] status_o
);
  frame_cfg_t         cfg;
  logic [CNT_W-1:0]   frame_bits;
  logic               brk_evt;
  logic [STICKY_N-1:0] set_vec;
  logic [STICKY_N-1:0] sticky;

  assign cfg = '{len_code: len_code_i, parity_on: parity_on_i, two_stop: two_stop_i};

  lsr_frame_len #(.CNT_W(CNT_W)) u_len (
    .cfg_i        (cfg),
    .frame_bits_o (frame_bits)
  );

  lsr_break_timer #(.CNT_W(CNT_W)) u_brk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (bit_tick_i),
    .line_i    (rx_line_i),
    .thresh_i  (frame_bits),
    .brk_evt_o (brk_evt)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[STK_OE] = overrun_stb_i;
    set_vec[STK_PE] = par_err_stb_i;
    set_vec[STK_FE] = frm_err_stb_i;
    set_vec[STK_BI] = brk_evt;
  end

  lsr_sticky_bank #(.N(STICKY_N)) u_stk (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (rd_stb_i),
    .flag_o (sticky)
  );

  always_comb begin
    status_o           = '0;
    status_o[BIT_DR]   = rst_n & rx_avail_i;
    status_o[BIT_OE]   = sticky[STK_OE];
    status_o[BIT_PE]   = sticky[STK_PE];
    status_o[BIT_FE]   = sticky[STK_FE];
    status_o[BIT_BI]   = sticky[STK_BI];
    status_o[BIT_THRE] = ~thr_full_i;
    status_o[BIT_TEMT] = ~thr_full_i & ~tsr_busy_i;
    status_o[BIT_FERR] = rst_n & fifo_mode_i & fifo_err_i;
  end
endmodule

// File: rtl/lsr_status_reg_chk.sv
module lsr_status_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb_i,
  input logic       par_err_stb_i,
  input logic       frm_err_stb_i,
  input logic       bit_tick_i,
  input logic       rx_line_i,
  input logic       fifo_mode_i,
  input logic [7:0] status_o
);
  // R2
  pe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_stb_i |=> status_o[2]);
  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && !par_err_stb_i) |=> !status_o[2]);
  // R3
  fe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3] && !rd_stb_i) |=> status_o[3]);
  // R10
  ferr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode_i |-> !status_o[7]);
  // R9
  temt_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6] |-> status_o[5]);
  // R11
  high_no_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick_i && rx_line_i) |=> !$rose(status_o[4]));
  // R3
  fe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err_stb_i |=> status_o[3]);
endmodule

bind lsr_status_reg lsr_status_reg_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_stb_i      (rd_stb_i),
  .par_err_stb_i (par_err_stb_i),
  .frm_err_stb_i (frm_err_stb_i),
  .bit_tick_i    (bit_tick_i),
  .rx_line_i     (rx_line_i),
  .fifo_mode_i   (fifo_mode_i),
  .status_o      (status_o)
);

// File: tb/lsr_status_reg_tb_top.sv
`timescale 1ns/1ps
module lsr_status_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_stb_i = 0, rx_avail_i = 0, overrun_stb_i = 0, par_err_stb_i = 0;
  logic frm_err_stb_i = 0, bit_tick_i = 0, rx_line_i = 1;
  logic [1:0] len_code_i = 2'd3;
  logic parity_on_i = 0, two_stop_i = 0;
  logic thr_full_i = 0, tsr_busy_i = 0, fifo_mode_i = 0, fifo_err_i = 0;
  logic [7:0] status_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lsr_status_reg dut_i (.*);

  // {thr_full, tsr_busy, fifo_mode, fifo_err, rx_avail, dr, thre, temt, ferr}
  localparam logic [8:0] VEC [0:7] = '{
    9'b00000_0110, 9'b10001_1000, 9'b01000_0100, 9'b11110_0001,
    9'b00111_1111, 9'b00010_0110, 9'b01101_1100, 9'b10111_1001
  };

  task automatic check(string req, logic [7:0] mask, logic [7:0] exp);
    n_chk++;
    if ((status_o & mask) !== (exp & mask)) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h (mask %02h)", req,
               status_o & mask, exp & mask, mask);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tick(logic v);
    @(negedge clk); bit_tick_i = 1; rx_line_i = v;
    @(negedge clk); bit_tick_i = 0;
  endtask

  task automatic read_word();
    @(negedge clk); rd_stb_i = 1;
    @(negedge clk); rd_stb_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rx_avail_i = 1; fifo_mode_i = 1; fifo_err_i = 1;
    cyc(); cyc();
    check("R1 reset", 8'hFF, 8'h60);
    rx_avail_i = 0; fifo_mode_i = 0; fifo_err_i = 0;
    cyc(); rst_n = 1;
    cyc();
    check("R1 after reset", 8'hFF, 8'h60);

    // R8 R9 R10 R4 vector walk
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {thr_full_i, tsr_busy_i, fifo_mode_i, fifo_err_i, rx_avail_i} = VEC[i][8:4];
      #1;
      check($sformatf("R8/R9/R10 vec %0d", i), 8'hE1,
            {VEC[i][0], VEC[i][1], VEC[i][2], 4'b0, VEC[i][3]});
    end
    {thr_full_i, tsr_busy_i, fifo_mode_i, fifo_err_i, rx_avail_i} = 5'b0;
    cyc();

    // R2 parity sticky
    @(negedge clk); par_err_stb_i = 1;
    @(negedge clk); par_err_stb_i = 0;
    check("R2 PE set", 8'h04, 8'h04);
    cyc(); cyc();
    check("R2 PE held", 8'h04, 8'h04);
    @(negedge clk); rd_stb_i = 1; #1;
    check("R2 read returns PE", 8'h04, 8'h04);
    @(negedge clk); rd_stb_i = 0;
    check("R2 PE cleared", 8'h1E, 8'h00);

    // R3 framing sticky
    @(negedge clk); frm_err_stb_i = 1;
    @(negedge clk); frm_err_stb_i = 0;
    cyc();
    check("R3 FE set", 8'h1E, 8'h08);
    read_word();
    check("R3 FE cleared", 8'h1E, 8'h00);

    // R4 overrun sticky, data ready not cleared by read
    rx_avail_i = 1;
    @(negedge clk); overrun_stb_i = 1;
    @(negedge clk); overrun_stb_i = 0;
    check("R4 OE set", 8'h03, 8'h03);
    read_word();
    check("R4 OE cleared, DR kept", 8'h03, 8'h01);
    rx_avail_i = 0;

    // R5 set with read in same cycle
    @(negedge clk); par_err_stb_i = 1;
    @(negedge clk); par_err_stb_i = 0; rd_stb_i = 1; frm_err_stb_i = 1; #1;
    check("R5 read shows old", 8'h0C, 8'h04);
    @(negedge clk); rd_stb_i = 0; frm_err_stb_i = 0;
    check("R5 new FE latched", 8'h0C, 8'h08);
    read_word();
    check("R5 FE cleared by next read", 8'h0C, 8'h00);

    // R6 break, 8N1 threshold 10
    len_code_i = 2'd3; parity_on_i = 0; two_stop_i = 0;
    for (int i = 0; i < 10; i++) tick(1'b0);
    check("R6 no break at 10 lows", 8'h10, 8'h00);
    tick(1'b0);
    check("R6 break at 11th low", 8'h10, 8'h10);
    // R7 one break per low period, counter saturates
    read_word();
    check("R7 BI cleared", 8'h10, 8'h00);
    for (int i = 0; i < 9; i++) tick(1'b0);
    check("R7 no second break, saturated", 8'h10, 8'h00);
    tick(1'b1);
    for (int i = 0; i < 11; i++) tick(1'b0);
    check("R7 rearmed after high", 8'h10, 8'h10);
    read_word();

    // R11 interrupted low run
    tick(1'b1);
    for (int i = 0; i < 9; i++) tick(1'b0);
    tick(1'b1);
    for (int i = 0; i < 9; i++) tick(1'b0);
    check("R11 split run no break", 8'h10, 8'h00);
    tick(1'b1);

    // R6 config 5 data, parity, 2 stop -> threshold 9
    len_code_i = 2'd0; parity_on_i = 1; two_stop_i = 1;
    for (int i = 0; i < 9; i++) tick(1'b0);
    check("R6 cfg2 no break at 9", 8'h10, 8'h00);
    tick(1'b0);
    check("R6 cfg2 break at 10", 8'h10, 8'h10);
    tick(1'b1);
    read_word();
    check("R6 BI cleared by read", 8'h1F, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule